// File: doc/BRIEF.md
# Triple-Copy Parameter Page Validator

This block receives a byte stream holding three back-to-back copies of a flash device's parameter page. Each copy is 256 bytes: 254 payload bytes, then a 16-bit checksum stored low byte first. As the bytes arrive, the block computes a CRC-16 over each copy's payload and compares it with that copy's stored checksum. It remembers which copies passed. Once all 768 bytes are in, it accepts the earliest copy that passed. If none passed, it runs a recovery pass. That pass takes a bitwise two-of-three majority of the three stored copies one byte per cycle, writes the result into a separate page buffer, and checks the voted page with the same CRC.

A host pulses `start_i`, streams the bytes over a valid/ready handshake, and waits for a one-cycle `done_o`. The `status_o` code that comes with `done_o` names the accepted source, or reports that every attempt failed. The accepted page can then be read one byte at a time through a combinational read port. A `start_i` that arrives while a run is in progress is ignored.

Top module: `ppv_triple_validator`

## Requirements
- R1: While reset is asserted and right after it, `in_ready_o` and `done_o` are low.
- R2: After `start_i` is sampled in the idle state, `in_ready_o` is high. A byte is taken on each clock edge where both `in_valid_i` and `in_ready_o` are high. `in_ready_o` falls once 768 bytes have been taken and stays low until the next start.
- R3: The checksum of a copy is CRC-16 with polynomial 0x8005, processed MSB first, seeded with 0x4F4E and with no final XOR. It runs over bytes 0..253 of that copy. It is compared with the value stored in byte 254 (low half) and byte 255 (high half).
- R4: Copies are tried in arrival order. When at least one copy passes, `status_o` is the index of the earliest passing copy (0, 1 or 2), even if later copies also pass.
- R5: When no copy passes, each bit of the recovered page is the majority of that bit across the three copies. If the recovered page passes the R3 check, `status_o` is 3.
- R6: If the recovered page fails the R3 check, `status_o` is 4, and the read port returns the voted page.
- R7: `done_o` is high for exactly one cycle, and `status_o` is valid in that cycle. `done_o` rises 1 cycle after `in_ready_o` falls when a copy passed. It rises 257 cycles after `in_ready_o` falls when the majority pass runs.
- R8: After `done_o`, `rd_data_o` combinationally returns byte `rd_addr_i` of the accepted page: the chosen copy for status 0..2, or the voted page for status 3 or 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new run (used only when idle) |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Block can take a byte |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | 0/1/2 copy index, 3 voted page ok, 4 failure |
| rd_addr_i | input | 8 | Byte address into the accepted page |
| rd_data_o | output | 8 | Byte of the accepted page |

## Verification
The hardest outcomes to reach from the ports are a recovered page that passes and a recovered page that fails. The first needs three copies that all fail on their own yet out-vote each other's errors. The second needs a flipped bit shared by at least two copies. The bench builds each copy from a known good page and flips chosen bits: different bytes or different bits of the same byte for recovery, and the same bit in two or three copies for failure. One flip lands in a checksum byte, to exercise the stored-field path.

// File: rtl/ppv_pkg.sv
`timescale 1ns/1ps
package ppv_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RECV,
        PH_PICK,
        PH_VOTE,
        PH_FIN
    } phase_e;

    typedef enum logic [2:0] {
        SRC_COPY0 = 3'd0,
        SRC_COPY1 = 3'd1,
        SRC_COPY2 = 3'd2,
        SRC_VOTED = 3'd3,
        SRC_NONE  = 3'd4
    } src_e;
endpackage

// File: rtl/ppv_crc_byte.sv
`timescale 1ns/1ps
// One byte of an MSB-first CRC update, no reflection.
module ppv_crc_byte #(
    parameter int          CW   = 16,
    parameter logic [15:0] POLY = 16'h8005
) (
    input  logic [CW-1:0] crc_i,
    input  logic [7:0]    byte_i,
    output logic [CW-1:0] crc_o
);
    always_comb begin
        logic [CW-1:0] c;
        c = crc_i;
        for (int b = 7; b >= 0; b--) begin
            if (c[CW-1] ^ byte_i[b]) c = {c[CW-2:0], 1'b0} ^ POLY[CW-1:0];
            else                     c = {c[CW-2:0], 1'b0};
        end
        crc_o = c;
    end
endmodule

// File: rtl/ppv_vote3.sv
`timescale 1ns/1ps
// Bitwise two-of-three majority.
module ppv_vote3 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] m_o
);
    assign m_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/ppv_store.sv
`timescale 1ns/1ps
// Byte array: one synchronous write port, NRD asynchronous read ports.
module ppv_store #(
    parameter int DEPTH = 768,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [NRD*AW-1:0] raddr_i,
    output logic [NRD*8-1:0]  rdata_o
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata_o[r*8 +: 8] = mem_q[raddr_i[r*AW +: AW]];
    end
endmodule

// File: rtl/ppv_triple_validator.sv
`timescale 1ns/1ps
module ppv_triple_validator #(
    parameter int          PAGE_BYTES = 256,
    parameter logic [15:0] CRC_POLY   = 16'h8005,
    parameter logic [15:0] CRC_SEED   = 16'h4F4E,
    localparam int         PAW        = $clog2(PAGE_BYTES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           in_valid_i,
    input  logic [7:0]     in_data_i,
    output logic           in_ready_o,
    output logic           done_o,
    output logic [2:0]     status_o,
    input  logic [PAW-1:0] rd_addr_i,
    output logic [7:0]     rd_data_o
);
    import ppv_pkg::*;

    localparam int COPIES     = 3;
    localparam int TOTAL      = PAGE_BYTES * COPIES;
    localparam int TAW        = $clog2(TOTAL);
    localparam int CIW        = TAW - PAW;
    localparam int DATA_BYTES = PAGE_BYTES - 2;

    typedef struct packed {
        phase_e          phase;
        logic [TAW-1:0]  cnt;
        logic [PAW-1:0]  idx;
        logic [15:0]     crc;
        logic [7:0]      lo;
        logic [2:0]      pass;
        src_e            src;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic        in_we, res_we;
    logic [7:0]  crc_byte, maj;
    logic [15:0] crc_upd;
    logic [2:0]  pass_flags;
    logic [4*TAW-1:0] cp_raddr;
    logic [4*8-1:0]   cp_rdata;
    logic [7:0]       res_rdata;

    assign pass_flags = ctl_q.pass;

    // ---------------- datapath pieces ----------------
    assign crc_byte = (ctl_q.phase == PH_RECV) ? in_data_i : maj;

    ppv_crc_byte #(.CW(16), .POLY(CRC_POLY)) u_crc (
        .crc_i (ctl_q.crc),
        .byte_i(crc_byte),
        .crc_o (crc_upd)
    );

    for (genvar k = 0; k < COPIES; k++) begin : g_vaddr
        assign cp_raddr[k*TAW +: TAW] = {CIW'(k), ctl_q.idx};
    end
    assign cp_raddr[3*TAW +: TAW] = {ctl_q.src[CIW-1:0], rd_addr_i};

    ppv_store #(.DEPTH(TOTAL), .NRD(4)) u_copies (
        .clk    (clk),
        .we_i   (in_we),
        .waddr_i(ctl_q.cnt),
        .wdata_i(in_data_i),
        .raddr_i(cp_raddr),
        .rdata_o(cp_rdata)
    );

    ppv_vote3 #(.W(8)) u_vote (
        .a_i(cp_rdata[0 +: 8]),
        .b_i(cp_rdata[8 +: 8]),
        .c_i(cp_rdata[16 +: 8]),
        .m_o(maj)
    );

    ppv_store #(.DEPTH(PAGE_BYTES), .NRD(1)) u_result (
        .clk    (clk),
        .we_i   (res_we),
        .waddr_i(ctl_q.idx),
        .wdata_i(maj),
        .raddr_i(rd_addr_i),
        .rdata_o(res_rdata)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        logic [PAW-1:0] pos;
        logic [CIW-1:0] cix;
        ctl_d  = ctl_q;
        in_we  = 1'b0;
        res_we = 1'b0;
        pos    = ctl_q.cnt[PAW-1:0];
        cix    = ctl_q.cnt[TAW-1:PAW];
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    ctl_d.phase = PH_RECV;
                    ctl_d.cnt   = '0;
                    ctl_d.crc   = CRC_SEED;
                    ctl_d.pass  = '0;
                    ctl_d.src   = SRC_NONE;
                end
            end
            PH_RECV: begin
                if (in_valid_i) begin
                    in_we = 1'b1;
                    if (pos < PAW'(DATA_BYTES)) begin
                        ctl_d.crc = crc_upd;
                    end else if (pos == PAW'(DATA_BYTES)) begin
                        ctl_d.lo = in_data_i;
                    end else begin
                        ctl_d.pass[cix] = (ctl_q.crc == {in_data_i, ctl_q.lo});
                        ctl_d.crc       = CRC_SEED;
                        if (ctl_q.cnt == TAW'(TOTAL - 1)) ctl_d.phase = PH_PICK;
                    end
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            PH_PICK: begin
                ctl_d.phase = PH_FIN;
                if      (ctl_q.pass[0]) ctl_d.src = SRC_COPY0;
                else if (ctl_q.pass[1]) ctl_d.src = SRC_COPY1;
                else if (ctl_q.pass[2]) ctl_d.src = SRC_COPY2;
                else begin
                    ctl_d.phase = PH_VOTE;
                    ctl_d.idx   = '0;
                    ctl_d.crc   = CRC_SEED;
                end
            end
            PH_VOTE: begin
                res_we = 1'b1;
                if (ctl_q.idx < PAW'(DATA_BYTES)) begin
                    ctl_d.crc = crc_upd;
                end else if (ctl_q.idx == PAW'(DATA_BYTES)) begin
                    ctl_d.lo = maj;
                end else begin
                    ctl_d.src   = (ctl_q.crc == {maj, ctl_q.lo}) ? SRC_VOTED : SRC_NONE;
                    ctl_d.phase = PH_FIN;
                end
                ctl_d.idx = ctl_q.idx + 1'b1;
            end
            PH_FIN: begin
                ctl_d.phase = PH_IDLE;
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.phase <= PH_IDLE;
            ctl_q.cnt   <= '0;
            ctl_q.idx   <= '0;
            ctl_q.crc   <= CRC_SEED;
            ctl_q.lo    <= '0;
            ctl_q.pass  <= '0;
            ctl_q.src   <= SRC_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready_o = (ctl_q.phase == PH_RECV);
    assign done_o     = (ctl_q.phase == PH_FIN);
    assign status_o   = ctl_q.src;
    assign rd_data_o  = (ctl_q.src == SRC_VOTED || ctl_q.src == SRC_NONE)
                        ? res_rdata : cp_rdata[3*8 +: 8];
endmodule

// File: rtl/ppv_checker.sv
`timescale 1ns/1ps
module ppv_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       in_ready_o,
    input logic       done_o,
    input logic [2:0] status_o,
    input logic [2:0] pass_flags
);
    a_r2_ready_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready_o && !start_i) |=> !in_ready_o);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_excl_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !in_ready_o);

    a_r4_first_copy_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && pass_flags[0]) |-> (status_o == 3'd0));

    a_r4_second_copy_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !pass_flags[0] && pass_flags[1]) |-> (status_o == 3'd1));

    a_r5_vote_only_if_all_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o >= 3'd3) |-> (pass_flags == 3'b000));

    a_r6_status_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o <= 3'd4));
endmodule

bind ppv_triple_validator ppv_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .in_ready_o(in_ready_o),
    .done_o    (done_o),
    .status_o  (status_o),
    .pass_flags(pass_flags)
);

// File: tb/ppv_triple_validator_bench.sv
`timescale 1ns/1ps
module ppv_triple_validator_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_data_i = '0;
    logic       in_ready_o, done_o;
    logic [2:0] status_o;
    logic [7:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    ppv_triple_validator u_ppv_triple_validator (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i),
        .in_ready_o(in_ready_o), .done_o(done_o), .status_o(status_o),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    // flip spec per copy: enable, byte position, bit position; expected status
    typedef struct packed {
        logic [2:0] en;
        logic [7:0] b0, b1, b2;
        logic [2:0] t0, t1, t2;
        logic [2:0] st;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{3'b000, 8'd0,   8'd0,   8'd0,   3'd0, 3'd0, 3'd0, 3'd0},
        '{3'b001, 8'd5,   8'd0,   8'd0,   3'd2, 3'd0, 3'd0, 3'd1},
        '{3'b011, 8'd5,   8'd100, 8'd0,   3'd2, 3'd6, 3'd0, 3'd2},
        '{3'b111, 8'd5,   8'd100, 8'd200, 3'd2, 3'd6, 3'd1, 3'd3},
        '{3'b111, 8'd17,  8'd17,  8'd17,  3'd3, 3'd3, 3'd3, 3'd4},
        '{3'b010, 8'd0,   8'd9,   8'd0,   3'd0, 3'd4, 3'd0, 3'd0},
        '{3'b101, 8'd255, 8'd0,   8'd0,   3'd7, 3'd0, 3'd5, 3'd1},
        '{3'b111, 8'd254, 8'd254, 8'd254, 3'd0, 3'd1, 3'd2, 3'd3},
        '{3'b110, 8'd0,   8'd3,   8'd3,   3'd0, 3'd7, 3'd7, 3'd0},
        '{3'b111, 8'd40,  8'd40,  8'd77,  3'd1, 3'd1, 3'd5, 3'd4}
    };

    logic [7:0] good [256];
    logic [7:0] cpy  [3][256];
    logic [7:0] voted[256];

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 7; b >= 0; b--) begin
            if (r[15] ^ d[b]) r = {r[14:0], 1'b0} ^ 16'h8005;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build(input int seed, input vec_t v);
        logic [15:0] c;
        c = 16'h4F4E;
        for (int j = 0; j < 254; j++) begin
            good[j] = 8'((j * 13 + seed * 29 + (j >> 3)) ^ (seed << 2));
            c = ref_crc(c, good[j]);
        end
        good[254] = c[7:0];
        good[255] = c[15:8];
        for (int k = 0; k < 3; k++)
            for (int j = 0; j < 256; j++) cpy[k][j] = good[j];
        if (v.en[0]) cpy[0][v.b0][v.t0] = ~cpy[0][v.b0][v.t0];
        if (v.en[1]) cpy[1][v.b1][v.t1] = ~cpy[1][v.b1][v.t1];
        if (v.en[2]) cpy[2][v.b2][v.t2] = ~cpy[2][v.b2][v.t2];
        for (int j = 0; j < 256; j++)
            voted[j] = (cpy[0][j] & cpy[1][j]) | (cpy[0][j] & cpy[2][j]) | (cpy[1][j] & cpy[2][j]);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(posedge clk);
        @(negedge clk); start_i = 1'b0;
    endtask

    // stream 768 bytes; optional idle gaps; returns cycles from ready fall to done
    task automatic stream(input bit gaps, output int lat);
        for (int n = 0; n < 768; n++) begin
            if (gaps && (n % 5 == 0)) begin
                in_valid_i = 1'b0;
                @(negedge clk);
            end
            in_valid_i = 1'b1;
            in_data_i  = cpy[n / 256][n % 256];
            @(posedge clk);
            @(negedge clk);
        end
        in_valid_i = 1'b0;
        check(in_ready_o == 1'b0, "R2 ready low after 768", in_ready_o, 0);
        lat = 0;
        while (!done_o && lat < 400) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_vec(input int i);
        int lat;
        int bad;
        int exp_lat;
        build(i, VECS[i]);
        pulse_start();
        check(in_ready_o == 1'b1, "R2 ready after start", in_ready_o, 1);
        stream(i % 2 == 1, lat);
        check(status_o == VECS[i].st, "R4/R5/R6 status", status_o, VECS[i].st);
        exp_lat = (VECS[i].st < 3) ? 1 : 257;
        check(lat == exp_lat, "R7 done latency", lat, exp_lat);
        bad = 0;
        for (int a = 0; a < 256; a++) begin
            logic [7:0] e;
            rd_addr_i = 8'(a);
            #0.01;
            e = (VECS[i].st < 3) ? cpy[VECS[i].st][a] : voted[a];
            if (rd_data_o !== e) bad++;
        end
        check(bad == 0, "R8 read port page", bad, 0);
        if (VECS[i].st == 3) begin
            bad = 0;
            for (int a = 0; a < 256; a++) if (voted[a] != good[a]) bad++;
            check(bad == 0, "R5 voted page restored", bad, 0);
        end
        @(negedge clk);
        check(done_o == 1'b0, "R7 done one cycle", done_o, 0);
        check(in_ready_o == 1'b0, "R2 ready low until start", in_ready_o, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready_o == 1'b0 && done_o == 1'b0, "R1 quiet in reset", {in_ready_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready_o == 1'b0 && done_o == 1'b0, "R1 quiet after reset", {in_ready_o, done_o}, 0);

        // vector table: R3 checksum, R4 order, R5 recovery, R6 failure
        for (int i = 0; i < 10; i++) run_vec(i);

        // directed: valid without start has no effect (R2)
        in_valid_i = 1'b1; in_data_i = 8'hA5;
        repeat (4) @(negedge clk);
        check(in_ready_o == 1'b0 && done_o == 1'b0, "R2 no start no accept", in_ready_o, 0);
        in_valid_i = 1'b0;

        // directed: start while busy is ignored, run completes after 768 bytes (R2)
        begin
            int lat;
            build(42, VECS[0]);
            pulse_start();
            for (int n = 0; n < 300; n++) begin
                in_valid_i = 1'b1; in_data_i = cpy[n / 256][n % 256];
                start_i = (n == 100);
                @(posedge clk); @(negedge clk);
            end
            start_i = 1'b0;
            for (int n = 300; n < 768; n++) begin
                in_valid_i = 1'b1; in_data_i = cpy[n / 256][n % 256];
                @(posedge clk); @(negedge clk);
            end
            in_valid_i = 1'b0;
            check(in_ready_o == 1'b0, "R2 busy start ignored", in_ready_o, 0);
            lat = 0;
            while (!done_o && lat < 400) begin @(negedge clk); lat++; end
            check(lat == 1 && status_o == 3'd0, "R4 result after busy start", status_o, 0);
        end

        // directed: reset mid-stream returns to quiet (R1)
        pulse_start();
        in_valid_i = 1'b1;
        repeat (10) @(negedge clk);
        in_valid_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready_o == 1'b0 && done_o == 1'b0, "R1 quiet after mid reset", in_ready_o, 0);

        finish_run();
    end
endmodule